// File: doc/BRIEF.md
# AFSK Framed Tone Transmitter

The block converts a stream of bytes into 8-bit unsigned audio samples that carry 1200 bit/s audio frequency-shift keying. The two tones are 1200 Hz for mark and 2200 Hz for space. Bytes arrive through a valid/ready handshake and wait in a single holding register. Whenever the engine is busy, each pulse of the sample enable produces exactly one new sample. The sample rate defaults to 9600 Hz, so each bit lasts 8 samples. The mark phase increment is then 64 and the space increment is 117 on a 512-step phase circle.

A frame starts on its own as soon as a byte is held while the block is idle. The frame is sent in this order:
- a number of 0x7E flags given on a port,
- the payload,
- a number of trailing flags given on another port.

Bits are sent least significant first. The payload uses HDLC-style zero insertion and NRZI tone changes. An escape code lets the user send the flag, abort and escape values as ordinary stuffed data. An escape with no byte after it aborts the frame.

Top module: `afsk_tx_top`

## Requirements
- R1: After reset, sample_o is 128, busy_o is 0 and ready_o is 1. Whenever busy_o is low, sample_o is 128.
- R2: sample_o changes only in a cycle with sample_en_i high. While busy_o is high, every enable produces one sample.
- R3: The 9-bit phase accumulator is cleared when a frame starts. Each sample adds 64 (mark) or 117 (space), modulo 512. Every bit, including an inserted one, lasts 8 samples.
- R4: The sample for phase p is built in three steps. First, h = p mod 256 and i = h, or 255-h when h >= 128. Second, v = round(127.5 + 127.5*sin(2*pi*i/512)), which gives values from 128 up to 255. Third, the output is 255-v when p >= 256, and v otherwise.
- R5: Bits are coded NRZI. A 1 keeps the current tone and a 0 swaps between mark and space. Each frame starts on mark. Each byte is sent LSB first.
- R6: A frame opens with preamble_len_i flag bytes (0x7E) and closes with trailer_len_i flag bytes. Both length ports are captured when the frame starts. These flags are never stuffed.
- R7: While stuffing is on, five 1 bits in a row are followed by an inserted 0, which is a tone swap, and the ones count then clears. The ones count carries across byte boundaries. Payload bytes 0x7E and 0x7F that are not escaped are sent with stuffing off.
- R8: Byte 0x1B is an escape. It is not transmitted, and the byte after it, of any value, is sent as stuffed data.
- R9: If an escape is waiting and no byte is held at a byte boundary, the frame ends at once without a trailer.
- R10: ready_o is low while the holding register is full. busy_o rises when a byte is held while idle. At a byte boundary where the register is empty and the trailer is used up, busy_o falls and sample_o returns to 128 on that enable.
- R11: A frame ends only at a bit boundary. The number of enables while busy, counting the final one, is 1 more than a multiple of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_en_i | input | 1 | One pulse per output sample period |
| valid_i | input | 1 | Input byte valid |
| data_i | input | 8 | Input byte |
| ready_o | output | 1 | Holding register can take a byte |
| preamble_len_i | input | 8 | Leading flag count, captured at frame start |
| trailer_len_i | input | 8 | Trailing flag count, captured at frame start |
| sample_o | output | 8 | Unsigned audio sample |
| busy_o | output | 1 | Frame in progress |

## Verification
A reference model in the bench turns each byte list into the exact expected sample sequence. Four frames are compared against it:
- The first mixes 0x00, 0xFF and the pair 0xF8/0x07. It separates NRZI swaps from kept tones and checks a stuffed 0 both inside a byte and across a byte boundary.
- The second sends unescaped flag and abort bytes between escaped 0x7E and escaped 0x1B. A wrong stuffing exemption or a leaked escape byte shifts every later sample.
- The third ends on a lone escape, which must cut the trailer.
- The fourth has no preamble and no trailer, which exposes off-by-one errors in the frame start and end.

// File: rtl/afsk_pkg.sv
package afsk_pkg;
  localparam int          PHASE_W = 9;
  localparam int          FULL    = 1 << PHASE_W;
  localparam int          QTR     = FULL / 4;
  localparam logic [7:0]  FLAG    = 8'h7E;
  localparam logic [7:0]  ABORT   = 8'h7F;
  localparam logic [7:0]  ESC     = 8'h1B;
  localparam logic [7:0]  MID     = 8'd128;
  localparam real         PI      = 3.14159265358979;

  function automatic logic [PHASE_W-1:0] tone_inc(input int hz, input int rate);
    return PHASE_W'((FULL * hz + rate / 2) / rate);
  endfunction

  // Taylor series, good to ~1e-7 over a quarter wave
  function automatic logic [7:0] quarter_sine(input int i);
    real x, x2, t, s;
    x  = 2.0 * PI * i / FULL;
    x2 = x * x;
    t  = x;
    s  = x;
    for (int k = 1; k < 8; k++) begin
      t = -t * x2 / ((2.0 * k) * (2.0 * k + 1.0));
      s = s + t;
    end
    return 8'($rtoi(127.5 + 127.5 * s + 0.5));
  endfunction
endpackage

// File: rtl/afsk_byte_src.sv
module afsk_byte_src
  import afsk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       ready_o,
  input  logic       pop_i,
  input  logic       drop_esc_i,
  output logic       hold_valid_o,
  output logic [7:0] hold_data_o,
  output logic       hold_esc_o,
  output logic       esc_pend_o
);
  logic       hv_q, he_q, ep_q;
  logic [7:0] hd_q;
  logic       take;

  assign ready_o = !hv_q;
  assign take    = valid_i && !hv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hv_q <= 1'b0;
      he_q <= 1'b0;
      ep_q <= 1'b0;
      hd_q <= '0;
    end else begin
      if (pop_i) hv_q <= 1'b0;
      if (drop_esc_i) ep_q <= 1'b0;
      if (take) begin
        if (!ep_q && data_i == ESC) begin
          ep_q <= 1'b1;
        end else begin
          hv_q <= 1'b1;
          hd_q <= data_i;
          he_q <= ep_q;
          ep_q <= 1'b0;
        end
      end
    end
  end

  assign hold_valid_o = hv_q;
  assign hold_data_o  = hd_q;
  assign hold_esc_o   = he_q;
  assign esc_pend_o   = ep_q;
endmodule

// File: rtl/afsk_framer.sv
module afsk_framer
  import afsk_pkg::*;
#(
  parameter int                 SPB       = 8,
  parameter int                 LEN_W     = 8,
  parameter logic [PHASE_W-1:0] MARK_INC  = 9'd64,
  parameter logic [PHASE_W-1:0] SPACE_INC = 9'd117
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               hold_valid_i,
  input  logic [7:0]         hold_data_i,
  input  logic               hold_esc_i,
  input  logic               esc_pend_i,
  input  logic [LEN_W-1:0]   pre_len_i,
  input  logic [LEN_W-1:0]   trl_len_i,
  output logic               pop_o,
  output logic               drop_esc_o,
  output logic               start_o,
  output logic               step_o,
  output logic               stop_o,
  output logic               busy_o,
  output logic [PHASE_W-1:0] inc_o
);
  localparam int CW = (SPB > 1) ? $clog2(SPB) : 1;
  localparam logic [3:0] BYTE_END = 4'd8;

  logic             busy_q, busy_n, mark_q, mark_n, stf_q, stf_n, go;
  logic [LEN_W-1:0] pre_q, pre_n, trl_q, trl_n;
  logic [7:0]       cur_q, cur_n;
  logic [3:0]       idx_q, idx_n;
  logic [2:0]       ones_q, ones_n;
  logic [CW-1:0]    cnt_q, cnt_n;

  always_comb begin
    busy_n = busy_q; mark_n = mark_q; stf_n = stf_q;
    pre_n  = pre_q;  trl_n  = trl_q;  cur_n = cur_q;
    idx_n  = idx_q;  ones_n = ones_q; cnt_n = cnt_q;
    pop_o = 1'b0; drop_esc_o = 1'b0; start_o = 1'b0;
    step_o = 1'b0; stop_o = 1'b0; go = 1'b1;
    if (!busy_q) begin
      if (hold_valid_i) begin
        start_o = 1'b1; busy_n = 1'b1;
        pre_n = pre_len_i; trl_n = trl_len_i;
        idx_n = BYTE_END; cnt_n = '0; mark_n = 1'b1; ones_n = '0;
      end
    end else if (tick_i) begin
      if (cnt_q != '0) begin
        cnt_n  = cnt_q - 1'b1;
        step_o = 1'b1;
      end else begin
        if (idx_q == BYTE_END) begin
          idx_n = '0;
          if (pre_q != '0) begin
            pre_n = pre_q - 1'b1; cur_n = FLAG; stf_n = 1'b0;
          end else if (hold_valid_i) begin
            pop_o = 1'b1; cur_n = hold_data_i;
            stf_n = hold_esc_i || !(hold_data_i == FLAG || hold_data_i == ABORT);
          end else if (esc_pend_i) begin
            go = 1'b0; drop_esc_o = 1'b1;
          end else if (trl_q != '0) begin
            trl_n = trl_q - 1'b1; cur_n = FLAG; stf_n = 1'b0;
          end else begin
            go = 1'b0;
          end
        end
        if (!go) begin
          busy_n = 1'b0; stop_o = 1'b1;
        end else begin
          step_o = 1'b1;
          cnt_n  = CW'(SPB - 1);
          if (stf_n && ones_q >= 3'd5) begin
            ones_n = '0; mark_n = !mark_q;
          end else begin
            if (cur_n[idx_n[2:0]]) begin
              if (ones_q != 3'd7) ones_n = ones_q + 1'b1;
            end else begin
              ones_n = '0; mark_n = !mark_q;
            end
            idx_n = idx_n + 1'b1;
          end
        end
      end
    end
    inc_o = mark_n ? MARK_INC : SPACE_INC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; mark_q <= 1'b1; stf_q <= 1'b0;
      pre_q <= '0; trl_q <= '0; cur_q <= '0;
      idx_q <= BYTE_END; ones_q <= '0; cnt_q <= '0;
    end else begin
      busy_q <= busy_n; mark_q <= mark_n; stf_q <= stf_n;
      pre_q <= pre_n; trl_q <= trl_n; cur_q <= cur_n;
      idx_q <= idx_n; ones_q <= ones_n; cnt_q <= cnt_n;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/afsk_dds.sv
module afsk_dds
  import afsk_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               step_i,
  input  logic               stop_i,
  input  logic [PHASE_W-1:0] inc_i,
  output logic [7:0]         sample_o
);
  logic [7:0]         rom [QTR];
  logic [PHASE_W-1:0] ph_q, ph_n;
  logic [6:0]         ix;
  logic [7:0]         qv, wave;
  logic [7:0]         smp_q;

  for (genvar g = 0; g < QTR; g++) begin : g_rom
    localparam logic [7:0] VAL = quarter_sine(g);
    assign rom[g] = VAL;
  end

  assign ph_n = ph_q + inc_i;
  assign ix   = ph_n[7] ? ~ph_n[6:0] : ph_n[6:0];
  assign qv   = rom[ix];
  assign wave = ph_n[8] ? 8'd255 - qv : qv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      smp_q <= MID;
    end else if (start_i) begin
      ph_q <= '0;
    end else if (step_i) begin
      ph_q  <= ph_n;
      smp_q <= wave;
    end else if (stop_i) begin
      smp_q <= MID;
    end
  end

  assign sample_o = smp_q;
endmodule

// File: rtl/afsk_tx_top.sv
module afsk_tx_top
  import afsk_pkg::*;
#(
  parameter int SAMPLE_RATE = 9600,
  parameter int BAUD        = 1200,
  parameter int MARK_HZ     = 1200,
  parameter int SPACE_HZ    = 2200,
  parameter int LEN_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_en_i,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  output logic             ready_o,
  input  logic [LEN_W-1:0] preamble_len_i,
  input  logic [LEN_W-1:0] trailer_len_i,
  output logic [7:0]       sample_o,
  output logic             busy_o
);
  localparam int                 SPB       = SAMPLE_RATE / BAUD;
  localparam logic [PHASE_W-1:0] MARK_INC  = tone_inc(MARK_HZ, SAMPLE_RATE);
  localparam logic [PHASE_W-1:0] SPACE_INC = tone_inc(SPACE_HZ, SAMPLE_RATE);

  logic             pop, drop_esc, hv, he, ep, start, step, stop;
  logic [7:0]       hd;
  logic [PHASE_W-1:0] inc;

  afsk_byte_src u_src (
    .clk_i, .rst_ni, .valid_i, .data_i, .ready_o,
    .pop_i(pop), .drop_esc_i(drop_esc),
    .hold_valid_o(hv), .hold_data_o(hd), .hold_esc_o(he), .esc_pend_o(ep)
  );

  afsk_framer #(
    .SPB(SPB), .LEN_W(LEN_W), .MARK_INC(MARK_INC), .SPACE_INC(SPACE_INC)
  ) u_frm (
    .clk_i, .rst_ni, .tick_i(sample_en_i),
    .hold_valid_i(hv), .hold_data_i(hd), .hold_esc_i(he), .esc_pend_i(ep),
    .pre_len_i(preamble_len_i), .trl_len_i(trailer_len_i),
    .pop_o(pop), .drop_esc_o(drop_esc), .start_o(start), .step_o(step),
    .stop_o(stop), .busy_o, .inc_o(inc)
  );

  afsk_dds u_dds (
    .clk_i, .rst_ni, .start_i(start), .step_i(step), .stop_i(stop),
    .inc_i(inc), .sample_o
  );
endmodule

// File: rtl/afsk_tx_chk.sv
module afsk_tx_chk
  import afsk_pkg::*;
#(
  parameter int SPB = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sample_en_i,
  input logic       valid_i,
  input logic [7:0] data_i,
  input logic       ready_o,
  input logic [7:0] sample_o,
  input logic       busy_o
);
  int unsigned tick_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tick_cnt <= 0;
    else if (!busy_o)     tick_cnt <= 0;
    else if (sample_en_i) tick_cnt <= tick_cnt + 1;
  end

  AST_IDLE_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sample_o == MID); // R1

  AST_SAMPLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i |=> $stable(sample_o)); // R2

  AST_HOLD_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && data_i != ESC) |=> !ready_o); // R10

  AST_BIT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (tick_cnt % SPB) == 1); // R11
endmodule

bind afsk_tx_top afsk_tx_chk #(.SPB(SPB)) u_chk (
  .clk_i, .rst_ni, .sample_en_i, .valid_i, .data_i, .ready_o, .sample_o, .busy_o
);

// File: tb/afsk_tx_top_tb_top.sv
`timescale 1ns/1ps
module afsk_tx_top_tb_top;
  logic       clk_i = 1'b0, rst_ni = 1'b0, sample_en_i = 1'b0, valid_i = 1'b0;
  logic [7:0] data_i = '0, preamble_len_i = '0, trailer_len_i = '0;
  logic       ready_o, busy_o;
  logic [7:0] sample_o;

  afsk_tx_top dut_i (.*);

  always #2 clk_i = ~clk_i;

  int    n_chk = 0, n_fail = 0;
  int    exp_q[$];
  logic [7:0] last_s = 8'd128;
  bit    mon_on = 1'b0;
  string cur_req = "R1";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_q(input int i);
    return $rtoi(127.5 + 127.5 * $sin(2.0 * 3.14159265358979 * i / 512.0) + 0.5);
  endfunction

  function automatic int ref_sine(input int ph);
    int h, ix, v;
    h  = ph % 256;
    ix = (h >= 128) ? 255 - h : h;
    v  = ref_q(ix);
    return (ph >= 256) ? 255 - v : v;
  endfunction

  // expected samples for a frame, from R3..R9
  task automatic model_frame(input logic [7:0] bytes[$], input int pre, input int trl);
    int  ph = 0, ones = 0;
    bit  mark = 1'b1, aborted = 1'b0;
    int  items[$];
    int  i = 0;
    for (int k = 0; k < pre; k++) items.push_back(32'h7E);
    while (i < bytes.size()) begin
      if (bytes[i] == 8'h1B) begin
        if (i + 1 < bytes.size()) begin
          items.push_back(256 | bytes[i+1]);
          i += 2;
        end else begin
          aborted = 1'b1;
          break;
        end
      end else begin
        items.push_back(((bytes[i] == 8'h7E || bytes[i] == 8'h7F) ? 0 : 256) | bytes[i]);
        i++;
      end
    end
    if (!aborted) for (int k = 0; k < trl; k++) items.push_back(32'h7E);
    foreach (items[n]) begin
      for (int b = 0; b < 8; b++) begin
        if (items[n][8] && ones >= 5) begin
          ones = 0; mark = !mark;
          for (int s = 0; s < 8; s++) begin
            ph = (ph + (mark ? 64 : 117)) % 512;
            exp_q.push_back(ref_sine(ph));
          end
        end
        if (items[n][b]) ones++;
        else begin ones = 0; mark = !mark; end
        for (int s = 0; s < 8; s++) begin
          ph = (ph + (mark ? 64 : 117)) % 512;
          exp_q.push_back(ref_sine(ph));
        end
      end
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    valid_i = 1'b1;
    data_i  = b;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic run_frame(input string lbl, input logic [7:0] bytes[$], input int pre, input int trl);
    bit esc = 1'b0;
    cur_req        = lbl;
    preamble_len_i = 8'(pre);
    trailer_len_i  = 8'(trl);
    model_frame(bytes, pre, trl);
    foreach (bytes[k]) begin
      push_byte(bytes[k]);
      if (!(bytes[k] == 8'h1B && !esc))
        check(ready_o == 1'b0, "R10 ready low while held", ready_o, 0);
      esc = (bytes[k] == 8'h1B && !esc);
    end
    while (exp_q.size() > 0 || busy_o) @(negedge clk_i);
    repeat (24) @(negedge clk_i);
  endtask

  // monitor: drives the enable and scores each sample
  initial begin
    bit pb;
    int e;
    wait (mon_on);
    forever begin
      repeat (3) @(negedge clk_i);
      check(sample_o == last_s, "R2 stable between enables", sample_o, last_s);
      pb = busy_o;
      sample_en_i = 1'b1;
      @(negedge clk_i);
      sample_en_i = 1'b0;
      if (pb) begin
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          check(sample_o == 8'(e) && busy_o, cur_req, {busy_o, sample_o}, 256 + e);
        end else begin
          check(sample_o == 8'd128 && !busy_o, "R10 frame end", {busy_o, sample_o}, 128);
        end
      end else begin
        check(sample_o == 8'd128, "R1 idle mid-scale", sample_o, 128);
      end
      last_s = sample_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    repeat (5) @(posedge clk_i);
    @(negedge clk_i);
    check(sample_o == 8'd128, "R1 reset sample", sample_o, 128);
    check(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
    check(ready_o == 1'b1, "R1 reset ready", ready_o, 1);
    rst_ni = 1'b1;
    mon_on = 1'b1;
    repeat (10) @(negedge clk_i);
    // NRZI, stuffing inside and across bytes
    q = {8'h00, 8'hFF, 8'hF8, 8'h07, 8'hA5};
    run_frame("R3 R4 R5 R6 R7 sample", q, 2, 1);
    // unescaped flag/abort, escaped flag and escape
    q = {8'h7E, 8'h7F, 8'h1B, 8'h7E, 8'h1B, 8'h1B, 8'h7F, 8'h3C};
    run_frame("R6 R7 R8 sample", q, 1, 2);
    // trailing lone escape aborts
    q = {8'h55, 8'h1B};
    run_frame("R9 sample", q, 1, 3);
    // no preamble, no trailer
    q = {8'h3C};
    run_frame("R10 R11 sample", q, 0, 0);
    check(busy_o == 1'b0 && sample_o == 8'd128, "R10 idle after frames", {busy_o, sample_o}, 128);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule